// File: doc/BRIEF.md
# Hint-Aware Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register of the outcomes of recent branches and combines it with the branch address by XOR to select one 2-bit saturating counter in an untagged table. The counter's upper bit is the prediction. When a branch is resolved, the counter it used is moved toward the real outcome. The outcome is then shifted into the history.

Each branch carries a 2-bit hint class. Only branches hinted as dynamic read the table, train it, or enter the history. Branches hinted as always-taken, never-taken or too-random-to-predict get a fixed answer and leave every piece of predictor state as it was. They therefore cannot displace statistics that belong to other branches. The front end sends the address and hint on the predict port, and it also records the history value that port shows. At resolve time it returns that snapshot together with the address, hint and actual outcome.

Top module: `brdir_pred`

## Requirements
- R1: After a synchronous active-low reset, the history output is all zeros and every counter holds 2'b01, so every dynamic prediction is not-taken.
- R2: Hint encoding is 2'b00 dynamic, 2'b01 always-taken, 2'b10 never-taken, 2'b11 unpredictable. Hint 2'b01 predicts taken. Hints 2'b10 and 2'b11 predict not-taken, whatever the table holds.
- R3: A dynamic prediction is combinational. It is the upper bit of the counter at index pred_pc[11:2] XOR the current history, with the default 1024 entries and 10 history bits.
- R4: A valid dynamic resolve with outcome taken increments the counter at index res_pc[11:2] XOR res_ghist, saturating at 3.
- R5: A valid dynamic resolve with outcome not-taken decrements that counter, saturating at 0.
- R6: The counter written on resolve is chosen by the history snapshot supplied with the resolve, not by the current history.
- R7: A valid dynamic resolve shifts its outcome into bit 0 of the history, and the older bits move up by one. The new value appears on pred_ghist in the next cycle.
- R8: A resolve whose hint is not dynamic changes neither the table nor the history.
- R9: Entries carry no address tag. Two addresses that differ only above bit 11 share a counter.
- R10: A predict and a resolve to the same index in the same cycle return the counter value from before the update.
- R11: With res_valid low, the table and the history are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | 32 | Address of the branch being predicted |
| pred_hint | input | 2 | Hint class of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ghist | output | 10 | Current global history, recorded as the snapshot |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_hint | input | 2 | Hint class of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_ghist | input | 10 | History snapshot recorded when this branch was predicted |

## Verification
The assertions assume that all inputs are known (not X) whenever reset is released. They also assume reset is held low for at least two clocks, so the table is fully initialised before any clocked property compares against a past value. The snapshot input is not assumed to match the live history. The stimulus therefore gives res_ghist sometimes the current history and sometimes an unrelated value, so that the snapshot-indexed write is exercised. Addresses are drawn from a narrow range so that aliasing and same-cycle predict/resolve collisions occur often. All four hint classes are mixed on both ports.

// File: rtl/bp_pkg.sv
// Package: shared hint-class encoding for the branch direction predictor.
// Assumes: hint values arrive as 2-bit codes and are cast to hint_e.
package bp_pkg;

    typedef enum logic [1:0] {
        HINT_DYN      = 2'b00,
        HINT_TAKEN    = 2'b01,
        HINT_NOTTAKEN = 2'b10,
        HINT_RANDOM   = 2'b11
    } hint_e;

    localparam logic [1:0] CTR_RESET = 2'b01;
    localparam logic [1:0] CTR_MAX   = 2'b11;
    localparam logic [1:0] CTR_MIN   = 2'b00;

endpackage

// File: rtl/brdir_hist.sv
// Module: global history shift register.
// Shifts one outcome in at bit 0 when shift_en is high, and otherwise holds.
// Assumes: HIST_W >= 2.
module brdir_hist #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] ghist
);

    logic [HIST_W-1:0] hist_q;

    // Holds or shifts the history; clears it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    assign ghist = hist_q;

    // R7: a shift places the outcome at bit 0 and moves the older bits up.
    assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[0] == $past(shift_bit))
                  && (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

    // R8/R11: with no shift, the history holds.
    assert_hist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/brdir_hash.sv
// Module: index hash. XORs the address bits above the 4-byte offset with the history.
// When the history is wider than the index, its low bits are used; when it is
// narrower, it is zero-extended.
// Assumes: PC_W >= IDX_W + 2.
module brdir_hash #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 10,
    parameter int IDX_W  = 10
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] ghist,
    output logic [IDX_W-1:0]  idx
);

    logic [IDX_W-1:0] hist_fit;

    generate
        if (HIST_W >= IDX_W) begin : g_trunc
            assign hist_fit = ghist[IDX_W-1:0];
        end else begin : g_extend
            assign hist_fit = {{(IDX_W-HIST_W){1'b0}}, ghist};
        end
    endgenerate

    // Combines the address slice with the fitted history.
    always_comb begin
        idx = pc[2 +: IDX_W] ^ hist_fit;
    end

endmodule

// File: rtl/brdir_table.sv
// Module: untagged table of 2-bit saturating counters.
// One combinational read port and one write port that moves a counter up or down.
// A read in the same cycle as a write sees the value from before the write.
// Assumes: DEPTH = 2**IDX_W.
module brdir_table #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    import bp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [1:0] ctr_q [DEPTH];
    logic [1:0] wr_cur;
    logic [1:0] wr_next;

    // Reads the current counter at the write index and forms its saturating successor.
    always_comb begin
        wr_cur  = ctr_q[wr_idx];
        wr_next = wr_cur;
        if (wr_taken && wr_cur != CTR_MAX) begin
            wr_next = wr_cur + 2'd1;
        end else if (!wr_taken && wr_cur != CTR_MIN) begin
            wr_next = wr_cur - 2'd1;
        end
    end

    // Initialises every counter to weakly not-taken; otherwise writes one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_RESET;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_next;
        end
    end

    assign rd_ctr = ctr_q[rd_idx];

    // R4: a taken update of a saturated counter leaves it at 3.
    assert_sat_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_cur == CTR_MAX) |=> (ctr_q[$past(wr_idx)] == CTR_MAX));

    // R5: a not-taken update of a zero counter leaves it at 0.
    assert_sat_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_cur == CTR_MIN) |=> (ctr_q[$past(wr_idx)] == CTR_MIN));

    // R4: a taken update never lowers the counter.
    assert_taken_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |=> (ctr_q[$past(wr_idx)] >= $past(wr_cur)));

    // R8/R11: without a write, the entry at the write index keeps its value.
    assert_no_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (ctr_q[$past(wr_idx)] == $past(wr_cur)));

endmodule

// File: rtl/brdir_pred.sv
// Module: hint-aware global-history branch direction predictor (top).
// Predict port: combinational direction from address and hint, plus the
// live history for the caller to keep as a snapshot.
// Resolve port: trains the table with the snapshot-indexed counter and shifts history.
// Only dynamic-hint branches touch state.
// Assumes: ENTRIES is a power of two; PC_W >= log2(ENTRIES) + 2.
module brdir_pred #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 1024,
    parameter int HIST_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pred_pc,
    input  logic [1:0]        pred_hint,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_ghist,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic [1:0]        res_hint,
    input  logic              res_taken,
    input  logic [HIST_W-1:0] res_ghist
);
    import bp_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    hint_e             p_hint;
    hint_e             r_hint;
    logic              train_en;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [1:0]        rd_ctr;
    logic [HIST_W-1:0] ghist;

    // Decodes the hint codes and qualifies training.
    always_comb begin
        p_hint   = hint_e'(pred_hint);
        r_hint   = hint_e'(res_hint);
        train_en = res_valid && (r_hint == HINT_DYN);
    end

    brdir_hist #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (train_en),
        .shift_bit (res_taken),
        .ghist     (ghist)
    );

    brdir_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_rd_hash (
        .pc    (pred_pc),
        .ghist (ghist),
        .idx   (rd_idx)
    );

    brdir_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_wr_hash (
        .pc    (res_pc),
        .ghist (res_ghist),
        .idx   (wr_idx)
    );

    brdir_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (train_en),
        .wr_idx   (wr_idx),
        .wr_taken (res_taken)
    );

    // Selects the fixed or counter-based direction by hint class.
    always_comb begin
        unique case (p_hint)
            HINT_DYN:      pred_taken = rd_ctr[1];
            HINT_TAKEN:    pred_taken = 1'b1;
            HINT_NOTTAKEN: pred_taken = 1'b0;
            default:       pred_taken = 1'b0;
        endcase
    end

    assign pred_ghist = ghist;

    // R2: the always-taken hint yields taken.
    assert_fixed_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_hint == 2'b01) |-> pred_taken);

    // R2: the never-taken and unpredictable hints yield not-taken.
    assert_fixed_not_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_hint[1]) |-> !pred_taken);

    // R8: a resolve with a non-dynamic hint leaves the history output unchanged.
    assert_static_no_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hint != 2'b00) |=> $stable(pred_ghist));

    // R11: an idle resolve port leaves the history output unchanged.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(pred_ghist));

endmodule

// File: tb/sim_brdir_pred.sv
module sim_brdir_pred;

    localparam int ENT  = 1024;
    localparam int HW   = 10;
    localparam int MASK = ENT - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic [1:0]  pred_hint = '0;
    logic        pred_taken;
    logic [9:0]  pred_ghist;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic [1:0]  res_hint = '0;
    logic        res_taken = 1'b0;
    logic [9:0]  res_ghist = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int tbl [ENT];
    int hist = 0;

    always #5ns clk = ~clk;

    brdir_pred u0 (
        .clk(clk), .rst_n(rst_n),
        .pred_pc(pred_pc), .pred_hint(pred_hint),
        .pred_taken(pred_taken), .pred_ghist(pred_ghist),
        .res_valid(res_valid), .res_pc(res_pc), .res_hint(res_hint),
        .res_taken(res_taken), .res_ghist(res_ghist)
    );

    function automatic int model_pred(input logic [31:0] pc, input logic [1:0] h);
        int idx;
        if (h == 2'b01) return 1;
        if (h != 2'b00) return 0;
        idx = ((pc >> 2) & MASK) ^ hist;
        return (tbl[idx] >= 2) ? 1 : 0;
    endfunction

    function automatic logic [31:0] pc_for(input int idx);
        return 32'((idx ^ hist) << 2);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the combinational outputs, then advance the model at the rising edge.
    task automatic cyc(input logic [31:0] ppc, input logic [1:0] ph,
                       input logic rv, input logic [31:0] rpc, input logic [1:0] rh,
                       input logic rt, input logic [9:0] rg,
                       input string tag, input int exp_p);
        int idx;
        pred_pc = ppc; pred_hint = ph;
        res_valid = rv; res_pc = rpc; res_hint = rh; res_taken = rt; res_ghist = rg;
        #1;
        check({tag, " pred"}, int'(pred_taken), model_pred(ppc, ph));
        check({tag, " hist"}, int'(pred_ghist), hist);
        if (exp_p >= 0) check({tag, " hand"}, int'(pred_taken), exp_p);
        @(posedge clk);
        if (rv && rh == 2'b00) begin
            idx = ((rpc >> 2) & MASK) ^ int'(rg);
            if (rt && tbl[idx] < 3) tbl[idx]++;
            else if (!rt && tbl[idx] > 0) tbl[idx]--;
            hist = ((hist << 1) | int'(rt)) & MASK;
        end
        @(negedge clk);
    endtask

    // Trains the counter at index 0 (address 0, snapshot 0) once, then checks its prediction.
    task automatic train0(input logic t, input string tag, input int exp_p);
        cyc(32'h0, 2'b00, 1'b1, 32'h0, 2'b00, t, 10'h0, tag, -1);
        cyc(pc_for(0), 2'b00, 1'b0, 32'h0, 2'b00, 1'b0, 10'h0, tag, exp_p);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENT; i++) tbl[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 hist", int'(pred_ghist), 0);
        cyc(32'h0, 2'b00, 1'b0, 0, 0, 0, 0, "R1", 0);
        cyc(32'h1230, 2'b00, 1'b0, 0, 0, 0, 0, "R1", 0);

        // R2: fixed hint predictions
        cyc(32'h0, 2'b01, 1'b0, 0, 0, 0, 0, "R2 taken", 1);
        cyc(32'h0, 2'b10, 1'b0, 0, 0, 0, 0, "R2 nottaken", 0);
        cyc(32'h0, 2'b11, 1'b0, 0, 0, 0, 0, "R2 random", 0);

        // R8: non-dynamic resolves do not touch state
        cyc(32'h0, 2'b00, 1'b1, 32'h0, 2'b01, 1'b1, 10'h0, "R8", 0);
        cyc(32'h0, 2'b00, 1'b1, 32'h0, 2'b10, 1'b1, 10'h0, "R8", 0);
        cyc(32'h0, 2'b00, 1'b1, 32'h0, 2'b11, 1'b1, 10'h0, "R8", 0);
        cyc(32'h0, 2'b00, 1'b0, 0, 0, 0, 0, "R8 after", 0);
        check("R8 hist", int'(pred_ghist), 0);

        // R11: idle resolve port with active data
        cyc(32'h0, 2'b00, 1'b0, 32'h0, 2'b00, 1'b1, 10'h0, "R11", 0);
        cyc(32'h0, 2'b00, 1'b0, 32'h0, 2'b00, 1'b1, 10'h0, "R11 after", 0);

        // R4: increment with saturation (1 -> 2 -> 3 -> 3 -> 3 -> 3)
        train0(1'b1, "R4 step1", 1);
        train0(1'b1, "R4 step2", 1);
        train0(1'b1, "R4 step3", 1);
        train0(1'b1, "R4 step4", 1);
        train0(1'b1, "R4 step5", 1);
        // R7: five taken outcomes give history 0x1F
        check("R7 hist", int'(pred_ghist), 32'h1F);

        // R5: decrement with saturation (3 -> 2 -> 1 -> 0 -> 0 -> 1 -> 2)
        train0(1'b0, "R5 down1", 1);
        train0(1'b0, "R5 down2", 0);
        train0(1'b0, "R5 down3", 0);
        train0(1'b0, "R5 down4", 0);
        train0(1'b1, "R5 up1", 0);
        train0(1'b1, "R5 up2", 1);
        // R7: history after outcomes 1,1,1,1,1,0,0,0,0,1,1
        check("R7 hist2", int'(pred_ghist), 32'h3C3);

        // R6: resolve uses the supplied snapshot (entry 5 ^ 3 = 6)
        cyc(32'h0, 2'b11, 1'b1, 32'h14, 2'b00, 1'b1, 10'h3, "R6", -1);
        cyc(32'h0, 2'b11, 1'b1, 32'h14, 2'b00, 1'b1, 10'h3, "R6", -1);
        cyc(pc_for(6), 2'b00, 1'b0, 0, 0, 0, 0, "R6 entry6", 1);

        // R9: an address differing only above the index bits shares the counter
        cyc(pc_for(6) | 32'h0010_0000, 2'b00, 1'b0, 0, 0, 0, 0, "R9 alias", 1);
        cyc(pc_for(6) | 32'h8000_3000, 2'b00, 1'b0, 0, 0, 0, 0, "R9 alias2", 1);

        // R10: same-cycle predict and resolve see the value from before the update
        cyc(pc_for(9), 2'b00, 1'b1, 32'h24, 2'b00, 1'b1, 10'h0, "R10 same", 0);
        cyc(pc_for(9), 2'b00, 1'b0, 0, 0, 0, 0, "R10 next", 1);

        // R3: mixed traffic compared against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] ppc;
            logic [31:0] rpc;
            logic [9:0]  rg;
            ppc = 32'(($urandom % 64) << 2) | ((($urandom % 4) == 0) ? 32'h0001_0000 : 32'h0);
            rpc = 32'(($urandom % 64) << 2);
            rg  = (($urandom % 2) == 0) ? 10'(hist) : 10'($urandom);
            if (($urandom % 5) == 0) rpc = ppc;
            cyc(ppc, 2'($urandom), ($urandom % 4) != 0, rpc, 2'($urandom % 6 > 3 ? $urandom : 0),
                1'($urandom), rg, "R3 random", -1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule